// File: doc/BRIEF.md
# Battery/Field Supply Switch Controller

This controller decides whether a low-power node runs from its battery or from the energy rectified out of a coil field. It watches two clean comparator levels, one that says the coil voltage is above the field-on threshold and one that says it has dropped below the field-off threshold. A move in either direction is taken only after the level has held without a break for a programmable dwell. The dwell is counted in ticks of an internal timebase, so a burst of interference at the coil does not flip the supply. The switch to field supply depends only on the coil, so a dead or missing battery does not block it.

Each return from field to battery starts a reset pulse of a set number of ticks. The pulse drives the host reset output and the internal logic reset low, so the host restarts cleanly after the supply glitch. The internal reset also follows power-on and an external active-low reset input. A command strobe from the serial interface can turn automatic management off. The node then stays on battery whatever the field does, until an enable command or a power-on reset. A separate field indicator tracks the coil with hysteresis and works in every mode. Its rising edge is the host wake-up event.

Top module: `supply_switch_ctrl`

## Requirements
- R1: With automatic management on and the supply on battery, `supply_field` goes to 1 only after `coil_above_on` has been high, with `coil_below_off` low, for BF_DWELL timebase ticks in a row. A window of at most (BF_DWELL-1)*TICK_DIV clock cycles never causes the switch. One tick comes every TICK_DIV clock cycles.
- R2: On field supply, `supply_field` goes back to 0 after `coil_below_off` has been high for FB_DWELL ticks in a row. The fall is seen between (FB_DWELL-1)*TICK_DIV+1 and FB_DWELL*TICK_DIV cycles after the level is applied. A shorter low window has no effect.
- R3: Every fall of `supply_field` drives `host_rst_n` and `core_rst_n` low in the same cycle. They stay low for RST_TICKS ticks and are high again within RST_TICKS*TICK_DIV+2 cycles. A rise of `supply_field` causes no reset.
- R4: While `por_n` is low, `supply_field`=0, `field_ind`=0, `host_rst_n`=0 and `core_rst_n`=0. Afterwards automatic management is on.
- R5: A low `ext_rst_n` drives `core_rst_n` low. It leaves `host_rst_n`, `supply_field` and the management mode unchanged.
- R6: A `cmd_stb` pulse with `cmd_auto`=0 turns management off. From field supply, it returns to battery on the next clock edge and starts the R3 reset pulse. While management is off, the supply stays on battery whatever the coil levels are.
- R7: Management that is off stays off through `ext_rst_n` pulses and held field levels. It turns on again only with a `cmd_stb` pulse with `cmd_auto`=1 or with a power-on reset. Once it is on again, R1 applies.
- R8: `field_ind` is 1 one cycle after `coil_above_on` is high and is 0 one cycle after `coil_below_off` is high. `coil_below_off` wins when both are high. With both low, `field_ind` holds its value. This holds in every management mode.
- R9: A break in the qualifying level restarts the dwell count, so two short windows split by a break never add up to a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; the timebase is divided from it |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset request, active low, synchronous |
| coil_above_on | input | 1 | Coil voltage above the field-on threshold |
| coil_below_off | input | 1 | Coil voltage below the field-off threshold |
| cmd_stb | input | 1 | One-cycle management command strobe |
| cmd_auto | input | 1 | With `cmd_stb`: 1 enables, 0 disables automatic management |
| supply_field | output | 1 | 1 = field supply selected, 0 = battery |
| field_ind | output | 1 | 1 = field present, 0 = gap or no field |
| host_rst_n | output | 1 | Reset to the host, active low |
| core_rst_n | output | 1 | Reset to the internal digital logic, active low |

## Verification
The hardest case to reach is a return to battery that comes from a disable command rather than from a fading field. The bench first holds the field-on level long enough to reach field supply, then strobes the disable command while the field is still present. It then keeps the field on and pulses the external reset to show that the disabled mode survives. The dwell boundaries are checked from the ports without knowing the timebase phase. Windows are sized to the tick count bounds, and the moment of the field-off return is measured and compared with its allowed range.

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl #(
  parameter int TICK_DIV  = 50,
  parameter int BF_DWELL  = 500,
  parameter int FB_DWELL  = 10000,
  parameter int RST_TICKS = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic coil_above_on,
  input  logic coil_below_off,
  input  logic cmd_stb,
  input  logic cmd_auto,
  output logic supply_field,
  output logic field_ind,
  output logic host_rst_n,
  output logic core_rst_n
);

  localparam int TW   = $clog2(TICK_DIV + 1);
  localparam int DMAX = (BF_DWELL > FB_DWELL) ? BF_DWELL : FB_DWELL;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int RW   = $clog2(RST_TICKS + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [DW-1:0] BF_LAST   = DW'(BF_DWELL - 1);
  localparam logic [DW-1:0] FB_LAST   = DW'(FB_DWELL - 1);
  localparam logic [RW-1:0] RST_LEN   = RW'(RST_TICKS);

  logic [TW-1:0] tdiv;
  logic [DW-1:0] dwell;
  logic [RW-1:0] rst_left;
  logic          auto_en;
  logic          tick;
  logic          on_ok;
  logic          off_cmd;
  logic          leave;
  logic          enter;

  assign tick    = (tdiv == TICK_LAST);
  assign on_ok   = coil_above_on && !coil_below_off;
  assign off_cmd = cmd_stb && !cmd_auto;

  assign enter = !supply_field && auto_en && !off_cmd && on_ok && tick && (dwell == BF_LAST);
  assign leave = supply_field &&
                 (off_cmd || (coil_below_off && tick && (dwell == FB_LAST)));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)    tdiv <= '0;
    else if (tick) tdiv <= '0;
    else           tdiv <= tdiv + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       auto_en <= 1'b1;
    else if (cmd_stb) auto_en <= cmd_auto;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      supply_field <= 1'b0;
      dwell        <= '0;
    end else if (enter || leave) begin
      supply_field <= enter;
      dwell        <= '0;
    end else if (!supply_field) begin
      if (!auto_en || off_cmd || !on_ok) dwell <= '0;
      else if (tick)                     dwell <= dwell + 1'b1;
    end else begin
      if (!coil_below_off) dwell <= '0;
      else if (tick)       dwell <= dwell + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                      rst_left <= '0;
    else if (leave)                  rst_left <= RST_LEN;
    else if (tick && rst_left != '0) rst_left <= rst_left - 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)              field_ind <= 1'b0;
    else if (coil_below_off) field_ind <= 1'b0;
    else if (coil_above_on)  field_ind <= 1'b1;

  assign host_rst_n = por_n && (rst_left == '0);
  assign core_rst_n = host_rst_n && ext_rst_n;

endmodule

module supply_switch_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic coil_above_on,
  input logic coil_below_off,
  input logic cmd_stb,
  input logic cmd_auto,
  input logic supply_field,
  input logic field_ind,
  input logic host_rst_n,
  input logic auto_en
);

  a_r1_enter_needs_field: assert property (@(posedge clk) disable iff (!por_n)
    $rose(supply_field) |-> $past(coil_above_on && !coil_below_off && auto_en));

  a_r2_leave_has_cause: assert property (@(posedge clk) disable iff (!por_n)
    $fell(supply_field) |-> ($past(coil_below_off) || $past(cmd_stb && !cmd_auto)));

  a_r3_reset_on_return: assert property (@(posedge clk) disable iff (!por_n)
    $fell(supply_field) |-> !host_rst_n);

  a_r6_disabled_on_batt: assert property (@(posedge clk) disable iff (!por_n)
    (!auto_en && $past(!auto_en)) |-> !supply_field);

  a_r8_gap_clears_ind: assert property (@(posedge clk) disable iff (!por_n)
    coil_below_off |=> !field_ind);

endmodule

bind supply_switch_ctrl supply_switch_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .coil_above_on(coil_above_on),
  .coil_below_off(coil_below_off), .cmd_stb(cmd_stb), .cmd_auto(cmd_auto),
  .supply_field(supply_field), .field_ind(field_ind),
  .host_rst_n(host_rst_n), .auto_en(auto_en)
);

// File: tb/supply_switch_ctrl_tb.sv
module supply_switch_ctrl_tb;
  localparam int DIV = 4;
  localparam int BF  = 8;
  localparam int FB  = 12;
  localparam int RT  = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1;
  logic above = 1'b0, below = 1'b0, stb = 1'b0, auto_c = 1'b0;
  logic supply_field, field_ind, host_rst_n, core_rst_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  supply_switch_ctrl #(.TICK_DIV(DIV), .BF_DWELL(BF), .FB_DWELL(FB), .RST_TICKS(RT)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .coil_above_on(above),
    .coil_below_off(below), .cmd_stb(stb), .cmd_auto(auto_c),
    .supply_field(supply_field), .field_ind(field_ind),
    .host_rst_n(host_rst_n), .core_rst_n(core_rst_n));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic command(logic en);
    stb = 1'b1; auto_c = en; step(1); stb = 1'b0;
  endtask

  task automatic go_field();
    below = 1'b0; above = 1'b1; step((BF + 1) * DIV + 2); above = 1'b0;
  endtask

  task automatic go_batt();
    above = 1'b0; below = 1'b1; step((FB + 1) * DIV + 2);
    below = 1'b0; step(RT * DIV + 2);
  endtask

  task automatic t_reset();
    step(3);
    chk("R4 supply", supply_field, 1'b0);
    chk("R4 ind", field_ind, 1'b0);
    chk("R4 host_rst", host_rst_n, 1'b0);
    chk("R4 core_rst", core_rst_n, 1'b0);
    por_n = 1'b1; step(2);
    chk("R4 host_rst released", host_rst_n, 1'b1);
    chk("R4 core_rst released", core_rst_n, 1'b1);
  endtask

  task automatic t_short_on();
    above = 1'b1; step(1);
    chk("R8 ind rise", field_ind, 1'b1);
    step((BF - 1) * DIV - 1);
    above = 1'b0; step(2);
    chk("R8 ind holds", field_ind, 1'b1);
    above = 1'b1; step((BF - 1) * DIV);
    above = 1'b0; step(1);
    chk("R1 R9 short windows no switch", supply_field, 1'b0);
  endtask

  task automatic t_to_field();
    above = 1'b1; step((BF - 1) * DIV);
    chk("R1 still battery", supply_field, 1'b0);
    step(2 * DIV + 2);
    chk("R1 switched to field", supply_field, 1'b1);
    chk("R3 no reset on entry", host_rst_n, 1'b1);
    above = 1'b0;
  endtask

  task automatic t_short_gap();
    below = 1'b1; step(1);
    chk("R8 ind fall", field_ind, 1'b0);
    step((FB - 1) * DIV - 1);
    below = 1'b0; step(2);
    below = 1'b1; step((FB - 1) * DIV);
    below = 1'b0; step(1);
    chk("R2 R9 short gaps no return", supply_field, 1'b1);
  endtask

  task automatic t_to_batt();
    int n = 0;
    below = 1'b1;
    while (supply_field === 1'b1 && n < (FB + 2) * DIV) begin
      step(1); n++;
    end
    checks++;
    if (n < (FB - 1) * DIV + 1 || n > FB * DIV) begin
      fails++;
      $display("FAIL R2 return delay: got %0d expected %0d..%0d", n, (FB - 1) * DIV + 1, FB * DIV);
    end
    chk("R3 host reset on return", host_rst_n, 1'b0);
    chk("R3 core reset on return", core_rst_n, 1'b0);
    step((RT - 1) * DIV - 1);
    chk("R3 pulse still low", host_rst_n, 1'b0);
    step(DIV + 3);
    chk("R3 pulse ended", host_rst_n, 1'b1);
    below = 1'b0;
  endtask

  task automatic t_ext_reset();
    ext_rst_n = 1'b0; step(1);
    chk("R5 core low", core_rst_n, 1'b0);
    chk("R5 host high", host_rst_n, 1'b1);
    chk("R5 supply kept", supply_field, 1'b0);
    ext_rst_n = 1'b1; step(1);
    chk("R5 core released", core_rst_n, 1'b1);
  endtask

  task automatic t_disable();
    go_field();
    above = 1'b1;
    command(1'b0);
    chk("R6 immediate return", supply_field, 1'b0);
    chk("R6 reset pulse", host_rst_n, 1'b0);
    step((BF + 4) * DIV);
    chk("R6 held on battery", supply_field, 1'b1 ^ 1'b1);
    ext_rst_n = 1'b0; step(2); ext_rst_n = 1'b1;
    step((BF + 4) * DIV);
    chk("R7 disable survives ext reset", supply_field, 1'b0);
    chk("R8 ind works when disabled", field_ind, 1'b1);
    command(1'b1);
    step((BF + 1) * DIV + 2);
    chk("R7 enable resumes switching", supply_field, 1'b1);
    above = 1'b0;
    go_batt();
  endtask

  task automatic t_por_clears();
    command(1'b0);
    por_n = 1'b0; step(2); por_n = 1'b1; step(1);
    go_field();
    chk("R7 R4 POR re-enables", supply_field, 1'b1);
    go_batt();
  endtask

  task automatic t_both();
    above = 1'b1; step(1);
    chk("R8 ind set", field_ind, 1'b1);
    below = 1'b1; step(1);
    chk("R8 below wins", field_ind, 1'b0);
    above = 1'b0; below = 1'b0; step(1);
  endtask

  initial begin
    t_reset();
    t_short_on();
    t_to_field();
    t_short_gap();
    t_to_batt();
    t_ext_reset();
    t_disable();
    t_por_clears();
    t_both();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule